// File: doc/BRIEF.md
# Panel Register Init Sequencer

This block brings a small RGB display controller into a working state straight after reset, with no processor involved. A single start pulse makes it claim a shared serial bus, then walk a fixed ROM of 24 register settings. For each setting it sends two 24-bit SPI frames:

- an index frame that names the register;
- a data frame that carries the new value.

Each frame has its own chip-select pulse.

Every frame opens with a header byte made of a six-bit device identifier and a register-select bit, followed by sixteen payload bits. The serial clock is derived from the system clock by a parameterised divider. Chip select is held high for a parameterised minimum time between frames.

An external abort, or the loss of the bus grant partway through, stops the walk at once, frees the bus and raises an error pulse. A finished walk raises a done pulse.

Top module: `panel_init_seq`

## Requirements
- R1: After reset the outputs are idle. `busy_o`, `done_o`, `error_o`, `bus_req_o`, `sclk_o` and `mosi_o` are 0, and `cs_n_o` is 1.
- R2: A start accepted while idle raises `bus_req_o` and `busy_o`. While `bus_gnt_i` is low, `cs_n_o` stays 1 and `sclk_o` stays 0, and no frame begins before the grant arrives.
- R3: One run sends exactly 48 frames of 24 bits each, two per ROM entry, taken in ROM order. For each entry the index frame goes first and the data frame second.
- R4: The frame layout is as follows. The header byte is 0x70 for an index frame and 0x72 for a data frame; bits 7..2 hold the identifier 011100 and bit 1 is the register-select bit. Then come 16 payload bits, most significant bit first: the register address in an index frame, the value in a data frame.
- R5: The ROM holds these address=value pairs in this send order:
  - 01=6300, 02=0200, 03=6564, 04=04C7, 05=A884, 08=00CE;
  - 0A=4008, 0B=D400, 0D=3229, 0E=1200, 0F=0000, 16=9F80;
  - 17=3F02, 1E=005C, 30=0103, 31=0407, 32=0705, 33=0002;
  - 34=0505, 35=0303, 36=0707, 37=0100, 3A=1F00, 3B=000F.
- R6: The SPI link runs in mode 0. `sclk_o` idles low, each half period lasts CLK_DIV system cycles, and `mosi_o` never changes while `sclk_o` is high inside a frame.
- R7: Between two consecutive frames of a run, `cs_n_o` stays high for at least CS_GAP serial clock periods, which is 2*CS_GAP*CLK_DIV system cycles.
- R8: When the 48th frame ends, `done_o` pulses for exactly one cycle. In that same cycle `busy_o` and `bus_req_o` are low.
- R9: A start while busy has no effect. The run goes on and still sends exactly 48 frames in ROM order with one done pulse.
- R10: `abort_i` while busy stops the run within one cycle. `cs_n_o` goes high, `bus_req_o` and `busy_o` go low, `error_o` pulses for one cycle and no further frame is sent. The next start begins again from the first ROM entry.
- R11: If `bus_gnt_i` falls while busy after the grant was given, the run ends the same way as an abort. The SPI outputs are forced idle at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one init run |
| bus_req_o | output | 1 | Bus request, high while a run is in progress |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| abort_i | input | 1 | External abort/error input |
| sclk_o | output | 1 | SPI serial clock, mode 0 |
| mosi_o | output | 1 | SPI serial data out, MSB first |
| cs_n_o | output | 1 | SPI chip select, active low, one pulse per frame |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the run completes |
| error_o | output | 1 | One-cycle pulse when a run is aborted |

## Verification
The bench decodes every frame from the SPI pins and compares all 48 against its own copy of the ROM. An off-by-one in the entry counter or phase flag would show up here as a skipped or repeated register, or as an index/data swap, and a wrong header bit would show as 0x70 and 0x72 being mixed up.

It holds the grant low after start, to catch a design that toggles chip select without owning the bus. It measures the high time of chip select between frames, to catch a gap counter that is too short. It fires a second start mid-run, which a design that restarts would punish with extra frames. It aborts and drops the grant mid-frame to check that the bus is freed at once and that the next run starts from entry zero, not from where the last one stopped.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;
  localparam int FRAME_W = 24;
  localparam int N_ENTRY = 24;
  localparam logic [5:0] DEV_ID = 6'b011100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_GAP
  } seq_st_e;

  // Header = identifier, register-select bit, write bit (always 0).
  function automatic logic [FRAME_W-1:0] build_frame(input logic is_data,
                                                     input logic [15:0] addr,
                                                     input logic [15:0] val);
    logic [7:0] head;
    head = {DEV_ID, is_data, 1'b0};
    return {head, (is_data ? val : addr)};
  endfunction
endpackage

// File: rtl/panel_init_rom.sv
module panel_init_rom #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      reg_addr_o,
  output logic [15:0]      reg_val_o
);
  always_comb begin
    case (idx_i)
      5'd0:  begin reg_addr_o = 16'h0001; reg_val_o = 16'h6300; end
      5'd1:  begin reg_addr_o = 16'h0002; reg_val_o = 16'h0200; end
      5'd2:  begin reg_addr_o = 16'h0003; reg_val_o = 16'h6564; end
      5'd3:  begin reg_addr_o = 16'h0004; reg_val_o = 16'h04C7; end
      5'd4:  begin reg_addr_o = 16'h0005; reg_val_o = 16'hA884; end
      5'd5:  begin reg_addr_o = 16'h0008; reg_val_o = 16'h00CE; end
      5'd6:  begin reg_addr_o = 16'h000A; reg_val_o = 16'h4008; end
      5'd7:  begin reg_addr_o = 16'h000B; reg_val_o = 16'hD400; end
      5'd8:  begin reg_addr_o = 16'h000D; reg_val_o = 16'h3229; end
      5'd9:  begin reg_addr_o = 16'h000E; reg_val_o = 16'h1200; end
      5'd10: begin reg_addr_o = 16'h000F; reg_val_o = 16'h0000; end
      5'd11: begin reg_addr_o = 16'h0016; reg_val_o = 16'h9F80; end
      5'd12: begin reg_addr_o = 16'h0017; reg_val_o = 16'h3F02; end
      5'd13: begin reg_addr_o = 16'h001E; reg_val_o = 16'h005C; end
      5'd14: begin reg_addr_o = 16'h0030; reg_val_o = 16'h0103; end
      5'd15: begin reg_addr_o = 16'h0031; reg_val_o = 16'h0407; end
      5'd16: begin reg_addr_o = 16'h0032; reg_val_o = 16'h0705; end
      5'd17: begin reg_addr_o = 16'h0033; reg_val_o = 16'h0002; end
      5'd18: begin reg_addr_o = 16'h0034; reg_val_o = 16'h0505; end
      5'd19: begin reg_addr_o = 16'h0035; reg_val_o = 16'h0303; end
      5'd20: begin reg_addr_o = 16'h0036; reg_val_o = 16'h0707; end
      5'd21: begin reg_addr_o = 16'h0037; reg_val_o = 16'h0100; end
      5'd22: begin reg_addr_o = 16'h003A; reg_val_o = 16'h1F00; end
      5'd23: begin reg_addr_o = 16'h003B; reg_val_o = 16'h000F; end
      default: begin reg_addr_o = 16'h0000; reg_val_o = 16'h0000; end
    endcase
  end
endmodule

// File: rtl/panel_frame_tx.sv
module panel_frame_tx #(
  parameter int CLK_DIV = 4,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               kill_i,
  output logic               active_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               frame_end_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic [DIV_W-1:0]   div_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               half_end;
  logic               last_bit;

  assign half_end    = (div_cnt == DIV_W'(CLK_DIV - 1));
  assign last_bit    = (bit_cnt == BIT_W'(FRAME_W - 1));
  // Frame ends on the falling edge that follows the last rising edge.
  assign frame_end_o = active_o && half_end && sclk_o && last_bit;
  assign mosi_o      = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      sclk_o   <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
    end else if (kill_i) begin
      active_o <= 1'b0;
      sclk_o   <= 1'b0;
      div_cnt  <= '0;
      shreg    <= '0;
    end else if (load_i && !active_o) begin
      active_o <= 1'b1;
      sclk_o   <= 1'b0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      shreg    <= frame_i;
    end else if (active_o) begin
      if (half_end) begin
        div_cnt <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
        end else begin
          sclk_o <= 1'b0;
          if (last_bit) begin
            active_o <= 1'b0;
            shreg    <= '0;
          end else begin
            shreg   <= {shreg[FRAME_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
  import panel_init_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic bus_req_o,
  input  logic bus_gnt_i,
  input  logic abort_i,
  output logic sclk_o,
  output logic mosi_o,
  output logic cs_n_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);
  localparam int IDX_W    = $clog2(N_ENTRY);
  localparam int GAP_CYC  = 2 * CS_GAP * CLK_DIV;
  localparam int GAP_W    = $clog2(GAP_CYC + 1);
  localparam int LAST_IDX = N_ENTRY - 1;

  seq_st_e            st;
  logic [IDX_W-1:0]   entry;
  logic               phase;      // 0 = index frame, 1 = data frame
  logic [GAP_W-1:0]   gap_cnt;
  logic [15:0]        rom_addr;
  logic [15:0]        rom_val;
  logic [FRAME_W-1:0] frame_word;

  // Named internal events, also observed by the checker.
  logic busy_w, kill, gap_end, load, frame_end, last_frame, seq_done;
  logic tx_active, tx_sclk, tx_mosi;

  panel_init_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i      (entry),
    .reg_addr_o (rom_addr),
    .reg_val_o  (rom_val)
  );

  assign frame_word = build_frame(phase, rom_addr, rom_val);

  assign busy_w     = (st != ST_IDLE);
  assign kill       = busy_w && (abort_i || (st != ST_REQ && !bus_gnt_i));
  assign gap_end    = (st == ST_GAP) && (gap_cnt == GAP_W'(GAP_CYC - 1));
  assign load       = !kill && (((st == ST_REQ) && bus_gnt_i) || gap_end);
  assign last_frame = phase && (entry == IDX_W'(LAST_IDX));
  assign seq_done   = (st == ST_XFER) && frame_end && last_frame && !kill;

  panel_frame_tx #(.CLK_DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .frame_i     (frame_word),
    .kill_i      (kill),
    .active_o    (tx_active),
    .sclk_o      (tx_sclk),
    .mosi_o      (tx_mosi),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      entry   <= '0;
      phase   <= 1'b0;
      gap_cnt <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o  <= seq_done;
      error_o <= kill;
      if (kill) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (start_i) begin
            st    <= ST_REQ;
            entry <= '0;
            phase <= 1'b0;
          end
          ST_REQ: if (load) st <= ST_XFER;
          ST_XFER: if (frame_end) begin
            if (last_frame) begin
              st <= ST_IDLE;
            end else begin
              st      <= ST_GAP;
              gap_cnt <= '0;
              phase   <= ~phase;
              if (phase) entry <= entry + 1'b1;
            end
          end
          ST_GAP: begin
            gap_cnt <= gap_cnt + 1'b1;
            if (gap_end) st <= ST_XFER;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign bus_req_o = busy_w;
  assign busy_o    = busy_w;
  assign cs_n_o    = ~(tx_active & bus_gnt_i);
  assign sclk_o    = tx_sclk & bus_gnt_i;
  assign mosi_o    = tx_mosi & tx_active & bus_gnt_i;
endmodule

// File: rtl/panel_init_seq_chk.sv
module panel_init_seq_chk #(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic bus_req_o,
  input logic bus_gnt_i,
  input logic abort_i,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic busy_o,
  input logic done_o,
  input logic error_o,
  input logic frame_end
);
  localparam int GAP_CYC = 2 * CS_GAP * CLK_DIV;

  int   hi_cnt;
  logic seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt     <= 0;
      seen_frame <= 1'b0;
    end else begin
      hi_cnt <= cs_n_o ? hi_cnt + 1 : 0;
      if (!busy_o) seen_frame <= 1'b0;
      else if (frame_end) seen_frame <= 1'b1;
    end
  end

  p_idle_spi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt_i |-> (cs_n_o && !sclk_o));

  p_cs_owns_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> bus_req_o);

  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && sclk_o && $past(sclk_o) && $past(!cs_n_o)) |-> $stable(mosi_o));

  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_frame && $fell(cs_n_o)) |-> (hi_cnt >= GAP_CYC));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !bus_req_o));

  p_abort_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> (!busy_o && cs_n_o && !bus_req_o && error_o));

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
endmodule

bind panel_init_seq panel_init_seq_chk #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req_o (bus_req_o),
  .bus_gnt_i (bus_gnt_i),
  .abort_i   (abort_i),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .cs_n_o    (cs_n_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .error_o   (error_o),
  .frame_end (frame_end)
);

// File: tb/panel_init_seq_bench.sv
`timescale 1ns/1ps
module panel_init_seq_bench;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 2;
  localparam int GAP_MIN = 2 * CS_GAP * CLK_DIV;

  // {address, value} per ROM entry, in send order (R5)
  localparam logic [31:0] TBL [24] = '{
    32'h0001_6300, 32'h0002_0200, 32'h0003_6564, 32'h0004_04C7,
    32'h0005_A884, 32'h0008_00CE, 32'h000A_4008, 32'h000B_D400,
    32'h000D_3229, 32'h000E_1200, 32'h000F_0000, 32'h0016_9F80,
    32'h0017_3F02, 32'h001E_005C, 32'h0030_0103, 32'h0031_0407,
    32'h0032_0705, 32'h0033_0002, 32'h0034_0505, 32'h0035_0303,
    32'h0036_0707, 32'h0037_0100, 32'h003A_1F00, 32'h003B_000F};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, bus_gnt_i = 1'b0, abort_i = 1'b0;
  logic bus_req_o, sclk_o, mosi_o, cs_n_o, busy_o, done_o, error_o;

  always #4 clk = ~clk;

  panel_init_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_panel_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bus_req_o(bus_req_o),
    .bus_gnt_i(bus_gnt_i), .abort_i(abort_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o),
    .error_o(error_o));

  int n_chk = 0, n_bad = 0;

  // Frame monitor, sampled on falling clock edges.
  logic [23:0] cap_w [64];
  int          cap_n [64];
  int          nfr, done_cnt, mosi_viol, min_gap, hi_run;
  logic [23:0] cur_w;
  int          cur_n;
  logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, clr_req = 1'b0;

  always @(negedge clk) begin
    if (clr_req) begin
      nfr = 0; done_cnt = 0; mosi_viol = 0; min_gap = 1000000; hi_run = 0;
    end else begin
      if (done_o) done_cnt++;
      if (!cs_n_o && p_cs) begin
        if (nfr > 0 && hi_run < min_gap) min_gap = hi_run;
        cur_w = '0; cur_n = 0;
      end
      if (!cs_n_o && sclk_o && !p_sclk) begin
        cur_w = {cur_w[22:0], mosi_o}; cur_n++;
      end
      if (!cs_n_o && sclk_o && p_sclk && mosi_o != p_mosi) mosi_viol++;
      if (cs_n_o && !p_cs && nfr < 64) begin
        cap_w[nfr] = cur_w; cap_n[nfr] = cur_n; nfr++;
      end
      hi_run = cs_n_o ? hi_run + 1 : 0;
    end
    p_sclk = sclk_o; p_cs = cs_n_o; p_mosi = mosi_o;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    clr_req = 1'b1; tick(); clr_req = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && done_cnt == 0; i++) tick();
  endtask

  // Walk the expected table over the captured frames (R3, R4, R5).
  task automatic check_run();
    logic [23:0] exp_w;
    check(nfr == 48, "R3 frame count", nfr, 48);
    for (int i = 0; i < 48 && i < nfr; i++) begin
      exp_w = (i % 2 == 1) ? {8'h72, TBL[i/2][15:0]} : {8'h70, TBL[i/2][31:16]};
      check(cap_n[i] == 24, "R3 frame bits", cap_n[i], 24);
      check(cap_w[i] == exp_w, "R4/R5 frame content", int'(cap_w[i]), int'(exp_w));
    end
    check(mosi_viol == 0, "R6 mosi moved while sclk high", mosi_viol, 0);
    check(min_gap >= GAP_MIN, "R7 cs_n gap", min_gap, GAP_MIN);
    check(done_cnt == 1, "R8 done pulses", done_cnt, 1);
    check(!busy_o && !bus_req_o, "R8 idle after done", {busy_o, bus_req_o}, 0);
  endtask

  int seen_bad, fr_at;

  initial begin : wdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr_req = 1'b1;
    repeat (3) tick();
    // R1: reset state
    check({busy_o, done_o, error_o, bus_req_o, sclk_o, mosi_o, cs_n_o} == 7'b0000001,
          "R1 reset outputs", {busy_o, done_o, error_o, bus_req_o, sclk_o, mosi_o, cs_n_o}, 1);
    rst_n = 1'b1; tick();
    clr_req = 1'b0; tick();

    // Run 1: grant withheld, then full run with a mid-run start (R2, R9)
    pulse_start();
    seen_bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (!bus_req_o || !busy_o || !cs_n_o || sclk_o) seen_bad++;
      tick();
    end
    check(seen_bad == 0, "R2 no activity before grant", seen_bad, 0);
    check(nfr == 0, "R2 no frame before grant", nfr, 0);
    bus_gnt_i = 1'b1;
    for (int i = 0; i < 5000 && nfr < 5; i++) tick();
    pulse_start();   // R9: ignored
    wait_done();
    tick();
    check_run();

    // Run 2: abort mid-frame (R10)
    clear_mon();
    pulse_start();
    for (int i = 0; i < 5000 && !(nfr >= 3 && !cs_n_o); i++) tick();
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    check(error_o == 1'b1, "R10 error pulse", error_o, 1);
    check(!busy_o && !bus_req_o && cs_n_o, "R10 bus released", {busy_o, bus_req_o, cs_n_o}, 1);
    tick();
    check(error_o == 1'b0, "R10 error one cycle", error_o, 0);
    fr_at = nfr;
    repeat (300) tick();
    check(nfr == fr_at, "R10 no frames after abort", nfr, fr_at);
    check(done_cnt == 0, "R10 no done after abort", done_cnt, 0);

    // Run 3: restart from first entry after abort (R10)
    clear_mon();
    pulse_start();
    wait_done();
    tick();
    check(nfr > 0 && cap_w[0] == 24'h700001, "R10 restart at entry 0", int'(cap_w[0]), 24'h700001);
    check_run();

    // Run 4: grant lost mid-frame (R11)
    clear_mon();
    pulse_start();
    for (int i = 0; i < 5000 && !(nfr >= 7 && !cs_n_o); i++) tick();
    bus_gnt_i = 1'b0; #1;
    check(cs_n_o && !sclk_o && !mosi_o, "R11 outputs idle at once", {cs_n_o, sclk_o, mosi_o}, 4);
    tick();
    check(error_o == 1'b1, "R11 error on grant loss", error_o, 1);
    check(!busy_o && !bus_req_o, "R11 released", {busy_o, bus_req_o}, 0);
    bus_gnt_i = 1'b1;
    fr_at = nfr;
    repeat (300) tick();
    check(nfr == fr_at && cs_n_o, "R11 stays stopped", nfr, fr_at);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule